// File: doc/BRIEF.md
# Four-Channel Register Access Decoder with Broadcast Write

This block sits between a host bus and a four-channel serial controller. Each access presents an active-low select, an 8-bit address and separate read and write strobes. The decoder sends the access to one of four per-channel register banks, to a shared configuration region, or to nowhere when the address is reserved. In this block each bank is a plain array of sixteen 8-bit registers.

The configuration region holds one control register. Its lowest bit is the broadcast flag. While the flag is set, a write aimed at any channel lands at the same offset in all four banks in the same cycle. This lets software set up identical channels with one pass of writes. Reads ignore the flag and always return data from the single channel named by the address. Read data is taken from the selected source and captured into an output register on the read strobe.

Top module: `chan_reg_decoder`

## Requirements
- R1: While `cs_n` is 1, no strobe has any effect: `chan_we` stays 0, no register changes, and `rdata` keeps its value.
- R2: With address bits 7:6 equal to 00, bits 5:4 select the channel (00 is channel 0, 11 is channel 3) and bits 3:0 select one of 16 registers in that channel. A write stores `wdata` there and a later read returns it.
- R3: Addresses with bit 7 = 0 and bit 6 = 1 are reserved. A write there asserts no bit of `chan_we` and changes no register. A read there returns 0x00.
- R4: When the broadcast flag is 1, a channel write asserts all four bits of `chan_we` and stores the data at the addressed offset in every channel.
- R5: When the broadcast flag is 1, a read still returns data from the one channel given by bits 5:4.
- R6: The broadcast control register is at address 0x8B. Only bit 0 is stored and it reads back as bit 0, with the other bits reading as 0. A write to this register asserts no bit of `chan_we`, whatever the flag's value.
- R7: When `rst_n` is 0, every channel register, the broadcast flag and `rdata` are cleared to 0.
- R8: When the broadcast flag is 0, at most one bit of `chan_we` is set. That bit is bit N for a write to channel N (1 = enable, bit 0 is channel 0).
- R9: `chan_we` follows the strobe in the same cycle. `rdata` changes only at the clock edge on which a selected read strobe is present, and it holds its value at all other times.
- R10: Configuration addresses other than 0x8B read as 0x00. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low access select |
| addr | input | 8 | Register address |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| chan_we | output | 4 | Per-channel write enables (bit N = channel N) |
| rdata | output | 8 | Registered read data |

## Verification
The bench writes a different value to each channel and reads every one of them back. A decoder that swapped or merged the channel field would return another channel's value. It then writes to a reserved address and checks that the write did not reach channel 0 and that the read returns zero. A decoder that ignored bit 6 would alias the reserved address onto channel 0.

With the broadcast flag set, the bench checks two things. A channel write must show all four enables and store the value in every bank. Reads must still return per-channel values that differ from each other, which catches a design that let the flag steer reads. A write to the configuration register itself must raise no channel enable.

Further checks cover the following:
- Accesses with `cs_n` high.
- The cycle in which `rdata` updates.
- Unused configuration offsets.
- A reset in the middle of the run with the flag set.

// File: rtl/chan_reg_pkg.sv
package chan_reg_pkg;
   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_CHAN = 2'd1,
      RGN_CFG  = 2'd2
   } rgn_e;
endpackage

// File: rtl/chan_addr_decode.sv
module chan_addr_decode
   import chan_reg_pkg::*;
#(
   parameter int AW      = 8,
   parameter int OFSW    = 4,
   parameter int CHW     = 2,
   parameter int CFG_OFS = 11
) (
   input  logic [AW-1:0]   addr,
   output rgn_e            rgn,
   output logic [CHW-1:0]  chan,
   output logic [OFSW-1:0] ofs,
   output logic            cfg_hit
);
   localparam int RSV_LSB = OFSW + CHW;
   localparam logic [AW-2:0] CFG_KEY = (AW-1)'(CFG_OFS);

   if (AW < RSV_LSB + 2) begin : g_bad_aw
      $error("chan_addr_decode: AW too small for offset and channel fields");
   end

   always_comb begin
      ofs     = addr[OFSW-1:0];
      chan    = addr[RSV_LSB-1:OFSW];
      cfg_hit = addr[AW-1] && (addr[AW-2:0] == CFG_KEY);
      if (addr[AW-1])
         rgn = RGN_CFG;
      else if (addr[AW-2:RSV_LSB] == '0)
         rgn = RGN_CHAN;
      else
         rgn = RGN_NONE;
   end
endmodule

// File: rtl/bcast_cfg_reg.sv
module bcast_cfg_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wbit,
   output logic bcast
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bcast <= 1'b0;
      else if (wr_en)
         bcast <= wbit;
   end
endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank #(
   parameter int DW      = 8,
   parameter int REGS    = 16,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [$clog2(REGS)-1:0] ofs,
   input  logic [DW-1:0]           wdata,
   output logic [DW-1:0]           rd_val
);
   logic [DW-1:0] mem [REGS];

   if (REGS < 2 || (REGS & (REGS - 1)) != 0) begin : g_bad_regs
      $error("chan_reg_bank: REGS must be a power of two of at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REGS; i++) mem[i] <= RST_VAL;
      end else if (we) begin
         mem[ofs] <= wdata;
      end
   end

   assign rd_val = mem[ofs];
endmodule

// File: rtl/chan_reg_decoder.sv
module chan_reg_decoder
   import chan_reg_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int AW      = 8,
   parameter int DW      = 8,
   parameter int REGS    = 16,
   parameter int CFG_OFS = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic [AW-1:0]  addr,
   input  logic           wr_stb,
   input  logic           rd_stb,
   input  logic [DW-1:0]  wdata,
   output logic [NCH-1:0] chan_we,
   output logic [DW-1:0]  rdata
);
   localparam int CHW  = $clog2(NCH);
   localparam int OFSW = $clog2(REGS);

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("chan_reg_decoder: NCH must be a power of two of at least 2");
   end
   if (CFG_OFS < 0 || CFG_OFS >= 2 ** (AW - 1)) begin : g_bad_cfg
      $error("chan_reg_decoder: CFG_OFS outside configuration region");
   end

   rgn_e            rgn;
   logic [CHW-1:0]  chan;
   logic [OFSW-1:0] ofs;
   logic            cfg_hit;
   logic            bcast;
   logic            acc_wr, acc_rd;
   logic [DW-1:0]   bank_rd [NCH];
   logic [DW-1:0]   rd_mux;

   assign acc_wr = !cs_n && wr_stb;
   assign acc_rd = !cs_n && rd_stb;

   chan_addr_decode #(.AW(AW), .OFSW(OFSW), .CHW(CHW), .CFG_OFS(CFG_OFS)) u_dec (
      .addr(addr), .rgn(rgn), .chan(chan), .ofs(ofs), .cfg_hit(cfg_hit)
   );

   bcast_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc_wr && cfg_hit), .wbit(wdata[0]), .bcast(bcast)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      assign chan_we[g] = acc_wr && (rgn == RGN_CHAN) && (bcast || chan == CHW'(g));
      chan_reg_bank #(.DW(DW), .REGS(REGS)) u_bank (
         .clk(clk), .rst_n(rst_n), .we(chan_we[g]),
         .ofs(ofs), .wdata(wdata), .rd_val(bank_rd[g])
      );
   end

   always_comb begin
      unique case (rgn)
         RGN_CHAN: rd_mux = bank_rd[chan];
         RGN_CFG:  rd_mux = cfg_hit ? DW'(bcast) : '0;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (acc_rd)
         rdata <= rd_mux;
   end

   AST_NO_WE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !wr_stb) |-> (chan_we == '0)); // R1
   AST_RSVD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr[AW-1] && addr[AW-2:CHW+OFSW] != '0) |-> (chan_we == '0)); // R3
   AST_BCAST_ALL_WE: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast && acc_wr && addr[AW-1:CHW+OFSW] == '0) |-> (&chan_we)); // R4
   AST_CFG_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      addr[AW-1] |-> (chan_we == '0)); // R6
   AST_SINGLE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !bcast |-> $onehot0(chan_we)); // R8
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> $stable(rdata)); // R9
endmodule

// File: tb/chan_reg_decoder_tb.sv
module chan_reg_decoder_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic [7:0] addr = '0;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] wdata = '0;
   logic [3:0] chan_we;
   logic [7:0] rdata;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   chan_reg_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_stb(wr_stb),
      .rd_stb(rd_stb), .wdata(wdata), .chan_we(chan_we), .rdata(rdata)
   );

   // {req, is_write, addr, wdata, expected (write: chan_we mask, read: rdata)}
   localparam int NV = 28;
   localparam logic [28:0] VEC [NV] = '{
      {4'd2, 1'b1, 8'h03, 8'h11, 8'h01},  // R2 ch0
      {4'd2, 1'b1, 8'h15, 8'h22, 8'h02},  // R2 ch1
      {4'd2, 1'b1, 8'h2F, 8'h33, 8'h04},  // R2 ch2
      {4'd2, 1'b1, 8'h30, 8'h44, 8'h08},  // R2 ch3
      {4'd2, 1'b0, 8'h03, 8'h00, 8'h11},
      {4'd2, 1'b0, 8'h15, 8'h00, 8'h22},
      {4'd2, 1'b0, 8'h2F, 8'h00, 8'h33},
      {4'd2, 1'b0, 8'h30, 8'h00, 8'h44},
      {4'd2, 1'b0, 8'h13, 8'h00, 8'h00},
      {4'd3, 1'b1, 8'h43, 8'h55, 8'h00},  // R3 reserved write
      {4'd3, 1'b0, 8'h43, 8'h00, 8'h00},
      {4'd3, 1'b0, 8'h03, 8'h00, 8'h11},  // R3 no alias onto ch0
      {4'd6, 1'b1, 8'h8B, 8'h01, 8'h00},  // R6 set flag, no channel enable
      {4'd6, 1'b0, 8'h8B, 8'h00, 8'h01},
      {4'd4, 1'b1, 8'h27, 8'h66, 8'h0F},  // R4 broadcast
      {4'd4, 1'b0, 8'h07, 8'h00, 8'h66},
      {4'd4, 1'b0, 8'h17, 8'h00, 8'h66},
      {4'd4, 1'b0, 8'h27, 8'h00, 8'h66},
      {4'd4, 1'b0, 8'h37, 8'h00, 8'h66},
      {4'd5, 1'b0, 8'h03, 8'h00, 8'h11},  // R5 reads stay per channel
      {4'd5, 1'b0, 8'h13, 8'h00, 8'h00},
      {4'd10, 1'b1, 8'h8C, 8'hFF, 8'h00}, // R10 unused cfg offset
      {4'd10, 1'b0, 8'h8C, 8'h00, 8'h00},
      {4'd10, 1'b0, 8'h8B, 8'h00, 8'h01},
      {4'd6, 1'b1, 8'h8B, 8'hFE, 8'h00},  // R6 clear flag, bit 0 only
      {4'd6, 1'b0, 8'h8B, 8'h00, 8'h00},
      {4'd8, 1'b1, 8'h09, 8'h77, 8'h01},  // R8 single enable
      {4'd8, 1'b0, 8'h19, 8'h00, 8'h00}
   };

   task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // one access; we_seen sampled mid-cycle, rdata valid when task returns
   task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         input logic csn, output logic [3:0] we_seen);
      @(negedge clk);
      cs_n = csn; addr = a; wdata = d; wr_stb = wr; rd_stb = !wr;
      #1 we_seen = chan_we;
      @(negedge clk);
      cs_n = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] we;
      // R7 reset state
      #1 chk(7, rdata, 8'h00, "rdata in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         v = VEC[i];
         access(v[24], v[23:16], v[15:8], 1'b0, we);
         if (v[24])
            chk(int'(v[28:25]), {4'b0, we}, v[7:0], $sformatf("vec %0d chan_we", i));
         else
            chk(int'(v[28:25]), rdata, v[7:0], $sformatf("vec %0d rdata", i));
      end

      // R1: deselected write and read
      access(1'b0, 8'h30, 8'h00, 1'b0, we);
      chk(1, rdata, 8'h44, "read ch3 before deselected access");
      access(1'b1, 8'h03, 8'hAA, 1'b1, we);
      chk(1, {4'b0, we}, 8'h00, "chan_we with cs_n high");
      access(1'b0, 8'h03, 8'h00, 1'b1, we);
      chk(1, rdata, 8'h44, "rdata held with cs_n high");

      // R9: rdata changes only at the read edge
      @(negedge clk);
      cs_n = 1'b0; addr = 8'h03; rd_stb = 1'b1;
      #1 chk(9, rdata, 8'h44, "rdata before read edge");
      @(negedge clk);
      cs_n = 1'b1; rd_stb = 1'b0;
      chk(9, rdata, 8'h11, "rdata after read edge (R1 write blocked)");
      @(negedge clk);
      chk(9, rdata, 8'h11, "rdata held after strobe");

      // R7: reset mid-run with flag set
      access(1'b1, 8'h8B, 8'h01, 1'b0, we);
      @(negedge clk);
      rst_n = 1'b0;
      #1 chk(7, rdata, 8'h00, "rdata cleared by reset");
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b0, 8'h27, 8'h00, 1'b0, we);
      chk(7, rdata, 8'h00, "channel reg cleared");
      access(1'b0, 8'h8B, 8'h00, 1'b0, we);
      chk(7, rdata, 8'h00, "flag cleared");
      access(1'b1, 8'h05, 8'h12, 1'b0, we);
      chk(7, {4'b0, we}, 8'h01, "single enable after reset");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule